// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Controller

This block holds the control registers of a game-cartridge memory mapper and translates processor and video addresses into banked memory addresses. The processor writes control bytes anywhere in the upper half of its address space. An index field picks one of eight bank registers for the next data write. Two mode bits decide which program and character windows are fixed and which can be switched.

From these registers the block forms a program-ROM address for each of four 8 KB processor windows and a character-memory address for each of eight 1 KB video windows. It also produces the nametable select line for horizontal or vertical mirroring, and the chip enable and write enable of the work RAM at 0x6000–0x7FFF. All translation is combinational from the current addresses and the registered state. Register writes take effect on the rising clock edge where `cpu_wr` is high.

The block has no state machine. Its only sequential part is the register file, which has two states per register: at reset, and loaded by a write. That state changes only on a qualified write (`cpu_wr` high and `cpu_addr[15]` high) or on reset.

Top module: `bank_map_ctrl`

## Requirements
- R1: Port decode looks only at `cpu_addr[15:13]` and `cpu_addr[0]`. Bits 12:1 do not matter, so for example 0x9FFE acts as 0x8000 and 0x8003 acts as 0x8001.
- R2: A write to the select port (A15:13=100, A0=0) stores the index from data bits 2:0, the program mode from bit 6 and the character mode from bit 7.
- R3: A write to the bank port (A15:13=100, A0=1) loads the indexed register. Registers 6 and 7 keep only data bits 5:0.
- R4: A bank-port write to register 0 or 1 stores the data with bit 0 forced to 0.
- R5: In character mode 0, slots 0/1 use register 0 with bank bit 0 set to 0 and then 1. Slots 2/3 use register 1 in the same way, and slots 4 to 7 use registers 2 to 5. The slot is `ppu_addr[12:10]`, and `chr_addr` = {bank[7:0], `ppu_addr[9:0]`}.
- R6: In character mode 1, the slot number has bit 2 inverted before the mapping of R5 is applied, which swaps the two 4 KB halves.
- R7: In program mode 0, windows 0 to 3 (`cpu_addr[14:13]`) map to register 6, register 7, bank PRG_BANKS-2 and bank PRG_BANKS-1. `prg_addr` = {bank[5:0], `cpu_addr[12:0]`}.
- R8: In program mode 1, windows 0 to 3 map to bank PRG_BANKS-2, register 7, register 6 and bank PRG_BANKS-1.
- R9: The mirroring port (A15:13=101, A0=0) stores data bit 0. `nt_a10` equals `ppu_addr[11]` when that bit is 1 and `ppu_addr[10]` when it is 0. While `four_screen` is 1, `nt_a10` equals `ppu_addr[10]` whatever the bit holds.
- R10: The RAM port (A15:13=101, A0=1) stores the enable from bit 7 and the protect flag from bit 6. `wram_ce` is 1 only when the RAM is enabled and `cpu_addr[15:13]`=011. `wram_we` is 1 only when `wram_ce` is 1, the RAM is not protected and `cpu_wr` is 1.
- R11: Reset clears the index, both modes, all eight bank registers, the mirroring bit and the RAM enable and protect flags.
- R12: Writes with `cpu_wr` low, writes with `cpu_addr[15]` low, and writes to the ports at 0xC000–0xFFFF change none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe |
| ppu_addr | input | 13 | Video address bits 12:0 |
| four_screen | input | 1 | Board strap that disables the mirroring control |
| prg_addr | output | 19 | Banked program-ROM address |
| chr_addr | output | 18 | Banked character-memory address |
| wram_ce | output | 1 | Work-RAM chip enable |
| wram_we | output | 1 | Work-RAM write enable |
| nt_a10 | output | 1 | Nametable A10 select |

## Verification
Some checks run on every cycle. One confirms that the last program window always yields the last bank. One confirms that the low bank bit of every paired character slot follows `ppu_addr[10]`. Others check that a RAM write strobe never appears without chip enable, that the four-screen strap pins `nt_a10` to `ppu_addr[10]`, and that no register changes in a cycle without a write strobe. The bench scenarios are needed for the rest: the masks on each bank register, the swapped window layouts in both modes, the mirrored port decode, writes that must be ignored, and the cleared state after a mid-run reset.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    localparam int PRG_BW    = 6;
    localparam int CHR_BW    = 8;
    localparam int CHR_REGS  = 6;
    localparam int PRG_REGS  = 2;

    typedef logic [CHR_BW-1:0] chr_bank_t;
    typedef logic [PRG_BW-1:0] prg_bank_t;
    typedef chr_bank_t [CHR_REGS-1:0] chr_file_t;
    typedef prg_bank_t [PRG_REGS-1:0] prg_file_t;

    typedef enum logic [2:0] {
        PORT_SELECT = 3'b000,
        PORT_BANK   = 3'b001,
        PORT_MIRROR = 3'b010,
        PORT_RAM    = 3'b011,
        PORT_IRQ_A  = 3'b100,
        PORT_IRQ_B  = 3'b101,
        PORT_IRQ_C  = 3'b110,
        PORT_IRQ_D  = 3'b111
    } port_e;
endpackage

// File: rtl/bmc_regfile.sv
module bmc_regfile
    import bmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] port,
    input  logic [7:0] wdata,
    output chr_file_t  chr_q,
    output prg_file_t  prg_q,
    output logic       prg_mode,
    output logic       chr_mode,
    output logic       mirror_h,
    output logic       ram_en,
    output logic       ram_wp
);
    logic [2:0] sel_q;
    port_e      port_s;

    assign port_s = port_e'(port);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            prg_mode <= 1'b0;
            chr_mode <= 1'b0;
            mirror_h <= 1'b0;
            ram_en   <= 1'b0;
            ram_wp   <= 1'b0;
            chr_q    <= '0;
            prg_q    <= '0;
        end else if (wr_en) begin
            unique case (port_s)
                PORT_SELECT: begin
                    sel_q    <= wdata[2:0];
                    prg_mode <= wdata[6];
                    chr_mode <= wdata[7];
                end
                PORT_BANK: begin
                    if (sel_q[2:1] == 2'b11)
                        prg_q[sel_q[0]] <= wdata[PRG_BW-1:0];
                    else if (sel_q[2:1] == 2'b00)
                        chr_q[sel_q] <= {wdata[7:1], 1'b0};
                    else
                        chr_q[sel_q] <= wdata;
                end
                PORT_MIRROR: mirror_h <= wdata[0];
                PORT_RAM: begin
                    ram_en <= wdata[7];
                    ram_wp <= wdata[6];
                end
                PORT_IRQ_A, PORT_IRQ_B, PORT_IRQ_C, PORT_IRQ_D: ;
            endcase
        end
    end

    // R12: register state holds in any cycle without a write
    a_r12_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({chr_q, prg_q, prg_mode, chr_mode, mirror_h, ram_en, ram_wp, sel_q}));
endmodule

// File: rtl/bmc_prg_xlat.sv
module bmc_prg_xlat
    import bmc_pkg::*;
#(
    parameter int PRG_BANKS = 64
) (
    input  logic [1:0] window,
    input  logic       prg_mode,
    input  prg_file_t  prg_q,
    output prg_bank_t  bank
);
    localparam prg_bank_t LAST_BANK   = prg_bank_t'(PRG_BANKS - 1);
    localparam prg_bank_t SECOND_LAST = prg_bank_t'(PRG_BANKS - 2);

    always_comb begin
        unique case (window)
            2'd0:    bank = prg_mode ? SECOND_LAST : prg_q[0];
            2'd1:    bank = prg_q[1];
            2'd2:    bank = prg_mode ? prg_q[0] : SECOND_LAST;
            default: bank = LAST_BANK;
        endcase
    end
endmodule

// File: rtl/bmc_chr_xlat.sv
module bmc_chr_xlat
    import bmc_pkg::*;
(
    input  logic [2:0] slot,
    input  logic       chr_mode,
    input  chr_file_t  chr_q,
    output chr_bank_t  bank
);
    logic [2:0] eff;

    assign eff = {slot[2] ^ chr_mode, slot[1:0]};

    always_comb begin
        if (eff[2])
            bank = chr_q[{1'b0, eff[1:0]} + 3'd2];
        else
            bank = {chr_q[{2'b00, eff[1]}][CHR_BW-1:1], eff[0]};
    end
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
    import bmc_pkg::*;
#(
    parameter int PRG_BANKS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    input  logic [12:0] ppu_addr,
    input  logic        four_screen,
    output logic [18:0] prg_addr,
    output logic [17:0] chr_addr,
    output logic        wram_ce,
    output logic        wram_we,
    output logic        nt_a10
);
    localparam prg_bank_t LAST_BANK = prg_bank_t'(PRG_BANKS - 1);

    chr_file_t chr_q;
    prg_file_t prg_q;
    logic      prg_mode, chr_mode, mirror_h, ram_en, ram_wp;
    prg_bank_t prg_bank;
    chr_bank_t chr_bank;

    bmc_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr & cpu_addr[15]),
        .port     ({cpu_addr[14:13], cpu_addr[0]}),
        .wdata    (cpu_data),
        .chr_q    (chr_q),
        .prg_q    (prg_q),
        .prg_mode (prg_mode),
        .chr_mode (chr_mode),
        .mirror_h (mirror_h),
        .ram_en   (ram_en),
        .ram_wp   (ram_wp)
    );

    bmc_prg_xlat #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .window   (cpu_addr[14:13]),
        .prg_mode (prg_mode),
        .prg_q    (prg_q),
        .bank     (prg_bank)
    );

    bmc_chr_xlat u_chr (
        .slot     (ppu_addr[12:10]),
        .chr_mode (chr_mode),
        .chr_q    (chr_q),
        .bank     (chr_bank)
    );

    assign prg_addr = {prg_bank, cpu_addr[12:0]};
    assign chr_addr = {chr_bank, ppu_addr[9:0]};
    assign wram_ce  = ram_en && (cpu_addr[15:13] == 3'b011);
    assign wram_we  = wram_ce && !ram_wp && cpu_wr;
    assign nt_a10   = (mirror_h && !four_screen) ? ppu_addr[11] : ppu_addr[10];

    // R7: the top window is always the last bank
    a_r7_last_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> (prg_addr[18:13] == LAST_BANK));
    // R5/R6: paired slots carry ppu_addr[10] as bank bit 0
    a_r5_pair_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_addr[12] == chr_mode) |-> (chr_addr[10] == ppu_addr[10]));
    // R10: a RAM write strobe implies chip enable and a processor write
    a_r10_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wram_we |-> (wram_ce && cpu_wr && cpu_addr[15:13] == 3'b011));
    // R9: four-screen strap overrides mirroring
    a_r9_four_screen: assert property (@(posedge clk) disable iff (!rst_n)
        four_screen |-> (nt_a10 == ppu_addr[10]));
endmodule

// File: tb/test_bank_map_ctrl.sv
`timescale 1ns/100ps
module test_bank_map_ctrl;
    localparam int PRG_BANKS = 64;

    logic        clk = 0, rst_n = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_data = 0;
    logic        cpu_wr = 0;
    logic [12:0] ppu_addr = 0;
    logic        four_screen = 0;
    logic [18:0] prg_addr;
    logic [17:0] chr_addr;
    logic        wram_ce, wram_we, nt_a10;

    int n_cmp = 0, n_bad = 0;

    logic [7:0] m_chr [6];
    logic [5:0] m_prg [2];
    logic [2:0] m_sel;
    logic       m_pm, m_cm, m_mh, m_en, m_wp;

    always #2.5 clk = ~clk;

    bank_map_ctrl #(.PRG_BANKS(PRG_BANKS)) i_bank_map_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .four_screen(four_screen),
        .prg_addr(prg_addr), .chr_addr(chr_addr), .wram_ce(wram_ce),
        .wram_we(wram_we), .nt_a10(nt_a10));

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 6; i++) m_chr[i] = 0;
        m_prg[0] = 0; m_prg[1] = 0;
        m_sel = 0; m_pm = 0; m_cm = 0; m_mh = 0; m_en = 0; m_wp = 0;
    endtask

    function automatic logic [5:0] exp_prg(input logic [1:0] w);
        case (w)
            2'd0:    return m_pm ? 6'(PRG_BANKS - 2) : m_prg[0];
            2'd1:    return m_prg[1];
            2'd2:    return m_pm ? m_prg[0] : 6'(PRG_BANKS - 2);
            default: return 6'(PRG_BANKS - 1);
        endcase
    endfunction

    function automatic logic [7:0] exp_chr(input logic [2:0] s);
        logic [2:0] e;
        e = m_cm ? (s ^ 3'b100) : s;
        case (e)
            3'd0: return m_chr[0] & 8'hFE;
            3'd1: return m_chr[0] | 8'h01;
            3'd2: return m_chr[1] & 8'hFE;
            3'd3: return m_chr[1] | 8'h01;
            default: return m_chr[e - 3'd2];
        endcase
    endfunction

    // write through ports; model follows the requirements
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = strobe;
        @(negedge clk);
        cpu_wr = 0;
        if (strobe && a[15]) begin
            case ({a[14:13], a[0]})
                3'b000: begin m_sel = d[2:0]; m_pm = d[6]; m_cm = d[7]; end
                3'b001: begin
                    if (m_sel >= 6)      m_prg[m_sel - 6] = d[5:0];
                    else if (m_sel <= 1) m_chr[m_sel] = d & 8'hFE;
                    else                 m_chr[m_sel] = d;
                end
                3'b010: m_mh = d[0];
                3'b011: begin m_en = d[7]; m_wp = d[6]; end
                default: ;
            endcase
        end
    endtask

    task automatic check_all(input string tag);
        for (int w = 0; w < 4; w++) begin
            logic [12:0] lo;
            lo = 13'($urandom);
            cpu_addr = {1'b1, 2'(w), lo}; cpu_wr = 0;
            #1;
            cmp($sformatf("%s R7/R8 prg w%0d", tag, w), 32'(prg_addr), 32'({exp_prg(2'(w)), lo}));
        end
        for (int s = 0; s < 8; s++) begin
            logic [9:0] lo;
            lo = 10'($urandom);
            ppu_addr = {3'(s), lo};
            #1;
            cmp($sformatf("%s R5/R6 chr s%0d", tag, s), 32'(chr_addr), 32'({exp_chr(3'(s)), lo}));
        end
        ppu_addr = 13'($urandom);
        #1;
        cmp({tag, " R9 nt_a10"}, 32'(nt_a10),
            32'((m_mh && !four_screen) ? ppu_addr[11] : ppu_addr[10]));
        cpu_addr = 16'h6000 | 16'($urandom % 16'h2000); cpu_wr = 1;
        #1;
        cmp({tag, " R10 ce"}, 32'(wram_ce), 32'(m_en));
        cmp({tag, " R10 we"}, 32'(wram_we), 32'(m_en && !m_wp));
        cpu_wr = 0;
        #1;
        cmp({tag, " R10 we idle"}, 32'(wram_we), 32'd0);
        cpu_addr = 16'h5FFF;
        #1;
        cmp({tag, " R10 ce outside"}, 32'(wram_ce), 32'd0);
    endtask

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R11 reset");

        // R2/R3/R4 directed
        wr(16'h8000, 8'h06, 1); wr(16'h8001, 8'hFF, 1);
        wr(16'h8000, 8'h07, 1); wr(16'h8001, 8'hC5, 1);
        wr(16'h8000, 8'h00, 1); wr(16'h8001, 8'h33, 1);
        wr(16'h8000, 8'h01, 1); wr(16'h8001, 8'hFF, 1);
        wr(16'h8000, 8'h02, 1); wr(16'h8001, 8'hA7, 1);
        check_all("R3/R4 masks mode0");
        wr(16'h8000, 8'hC0, 1);
        check_all("R2 both modes set");

        // R1 mirrored decode
        wr(16'h9FFE, 8'h05, 1); wr(16'h8003, 8'h9B, 1);
        wr(16'hBFFE, 8'h01, 1); wr(16'hA5A7, 8'h80, 1);
        check_all("R1 mirrored ports");

        // R12 ignored writes
        wr(16'h8001, 8'h11, 0);
        wr(16'h0001, 8'h22, 1); wr(16'h6000, 8'h33, 1);
        wr(16'hC000, 8'h44, 1); wr(16'hC001, 8'h55, 1);
        wr(16'hE000, 8'h66, 1); wr(16'hE001, 8'h77, 1);
        check_all("R12 ignored");

        // R9 four-screen strap
        four_screen = 1;
        check_all("R9 four-screen");
        four_screen = 0;

        // random stimulus
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            a = {1'b1, 15'($urandom)};
            if ($urandom % 8 == 0) a[15] = 0;
            wr(a, 8'($urandom), ($urandom % 6) != 0);
            if (k % 20 == 0) begin
                four_screen = ($urandom % 4) == 0;
                check_all("rand");
            end
        end
        four_screen = 0;

        // R11 mid-run reset
        wr(16'hA001, 8'h80, 1); wr(16'hA000, 8'h01, 1); wr(16'h8000, 8'hC3, 1);
        @(negedge clk); rst_n = 0; model_reset();
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check_all("R11 mid reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule